// File: doc/BRIEF.md
# SPI Slave Shift Engine with Mode-Fault Detection

This block is the serial shift engine of an SPI slave. It moves 8-bit words in both directions, most significant bit first. It receives the serial clock, the active-low select line and the master-out data from pins that are not synchronous to the system clock. Each of these passes through a chain of flip-flops before its edges are detected in the system clock domain. Run-time inputs set the idle level of the clock (`cpol`) and the clock phase (`cpha`). When phase is 0, the engine samples on the first clock edge of each bit. When phase is 1, it samples on the second edge.

When phase is 0, selecting the slave starts a transfer. When phase is 1, the first clock edge away from idle starts a transfer, and only while the slave is already selected. If the select line is released while a transfer is active, the transfer is dropped at once and a one-cycle fault pulse is raised. A fault changes neither the enable nor any other setting. Clearing `en` is the only way to abort a transfer without raising a fault. After an abort, the next selection starts a fresh word.

Top module: `spi_target_shifter`

## Requirements
- R1: After reset, `miso_oe`, `rx_done` and `mode_fault` are 0. `miso_oe` is 1 only while `en` is 1 and the synchronized select line is low.
- R2: When `cpha`=0, the falling edge of select starts a transfer. Bit 7 of `tx_byte` appears on `miso` before any clock edge. The following bits appear from bit 7 down to bit 0, one per clock cycle.
- R3: When `cpha`=0, MOSI is sampled on each clock edge away from idle, and the next MISO bit is shifted out on each return to idle. The return to idle after the 8th sample ends the word. At that point `rx_done` pulses for one cycle and `rx_data` holds the received word, with the first bit received at bit 7.
- R4: When `cpha`=1, a transfer starts on the first clock edge away from idle while the slave is selected. MISO shifts on edges away from idle, and MOSI is sampled on each return to idle. The 8th return to idle completes the word. Another word may follow while select stays low.
- R5: `cpol`=0 makes low the idle clock level, and `cpol`=1 makes high the idle level. Both phases work with either polarity.
- R6: If select goes high while a transfer is active, `mode_fault` pulses for one cycle, the partial word is discarded, and `rx_done` does not pulse.
- R7: When `cpha`=0, selecting and then deselecting with no clock edges raises `mode_fault`. When `cpha`=1, the same sequence raises none.
- R8: Clock edges that arrive while select is high are ignored. They give no `rx_done` and no `mode_fault`, and they do not advance the bit position of the next word.
- R9: A fault does not clear `en`, and the next word is received normally. Clearing `en` part way through a word aborts it without `mode_fault` or `rx_done`, and the next selection starts a fresh word.
- R10: If the clock edge that would complete a word falls in the same cycle as the rise of select, the deselect wins. `mode_fault` pulses and `rx_done` does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Engine enable; 0 aborts any transfer |
| cpol | input | 1 | Idle level of the serial clock |
| cpha | input | 1 | Clock phase: 0 samples on first edge, 1 on second |
| sck_in | input | 1 | Serial clock from the master (asynchronous) |
| ss_n_in | input | 1 | Active-low select (asynchronous) |
| mosi_in | input | 1 | Serial data from the master (asynchronous) |
| tx_byte | input | 8 | Word to send, loaded at the start of a transfer |
| miso | output | 1 | Serial data to the master |
| miso_oe | output | 1 | Output enable for the MISO tri-state driver |
| rx_data | output | 8 | Last completed received word |
| rx_done | output | 1 | One-cycle pulse when a word completes |
| mode_fault | output | 1 | One-cycle pulse when select is released mid-transfer |

## Verification
The two events that can fall in the same system clock cycle are word completion and the deselect fault. The bench provokes this in phase-1 mode by driving the final return of the clock to idle and the release of select at the same instant. Both inputs then cross identical synchronizer chains and reach the edge detector together. The scoreboard must see no received word, and the fault counter must rise by exactly one.

// File: rtl/spi_sl_pkg.sv
package spi_sl_pkg;

   // Edge events seen in the system clock domain during one cycle
   typedef struct packed {
      logic lead;      // serial clock left its idle level
      logic trail;     // serial clock returned to its idle level
      logic sel_fall;  // select became active (low)
      logic sel_rise;  // select was released (high)
   } spi_evt_t;

endpackage

// File: rtl/spi_sl_sync.sv
module spi_sl_sync #(
   parameter int             W       = 3,
   parameter int             STAGES  = 2,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("spi_sl_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("spi_sl_sync: W must be at least 1");
   end

   for (genvar i = 0; i < W; i++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= {STAGES{RST_VAL[i]}};
         else        chain <= {chain[STAGES-2:0], d[i]};
      end
      assign q[i] = chain[STAGES-1];
   end

endmodule

// File: rtl/spi_sl_edges.sv
module spi_sl_edges
   import spi_sl_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     cpol,
   input  logic     sck_s,
   input  logic     ss_s,
   output spi_evt_t evt
);

   logic sck_prev_q;
   logic ss_prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_prev_q <= 1'b0;
         ss_prev_q  <= 1'b1;
      end else begin
         sck_prev_q <= sck_s;
         ss_prev_q  <= ss_s;
      end
   end

   logic sck_chg;
   assign sck_chg = sck_s ^ sck_prev_q;

   always_comb begin
      evt.lead     = sck_chg & (sck_s != cpol);
      evt.trail    = sck_chg & (sck_s == cpol);
      evt.sel_fall = ss_prev_q & ~ss_s;
      evt.sel_rise = ~ss_prev_q & ss_s;
   end

   // R3 lead and trail are exclusive in any cycle
   edge_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(evt.lead && evt.trail));

endmodule

// File: rtl/spi_sl_shifter.sv
module spi_sl_shifter
   import spi_sl_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              cpha,
   input  spi_evt_t          evt,
   input  logic              ss_s,
   input  logic              mosi_s,
   input  logic [DATA_W-1:0] tx_byte,
   output logic              miso,
   output logic              miso_oe,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_done,
   output logic              mode_fault
);

   localparam int                CNT_W   = $clog2(DATA_W + 1);
   localparam logic [CNT_W-1:0]  LAST    = CNT_W'(DATA_W);
   localparam logic [CNT_W-1:0]  LAST_M1 = CNT_W'(DATA_W - 1);

   if (DATA_W < 2) begin : g_bad_width
      $error("spi_sl_shifter: DATA_W must be at least 2");
   end

   logic              active_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [DATA_W-1:0] tx_q;
   logic [DATA_W-1:0] rx_q;
   logic [DATA_W-1:0] rx_data_q;
   logic              done_q;
   logic              fault_q;

   logic [DATA_W-1:0] rx_next;
   logic [DATA_W-1:0] tx_shift;
   assign rx_next  = {rx_q[DATA_W-2:0], mosi_s};
   assign tx_shift = {tx_q[DATA_W-2:0], 1'b0};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q  <= 1'b0;
         cnt_q     <= '0;
         tx_q      <= '0;
         rx_q      <= '0;
         rx_data_q <= '0;
         done_q    <= 1'b0;
         fault_q   <= 1'b0;
      end else begin
         done_q  <= 1'b0;
         fault_q <= 1'b0;
         if (!en) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
         end else if (evt.sel_rise) begin
            fault_q  <= active_q;
            active_q <= 1'b0;
            cnt_q    <= '0;
         end else if (!ss_s) begin
            if (!cpha) begin
               if (evt.sel_fall) begin
                  active_q <= 1'b1;
                  cnt_q    <= '0;
                  tx_q     <= tx_byte;
               end else if (active_q && evt.lead && cnt_q != LAST) begin
                  rx_q  <= rx_next;
                  cnt_q <= cnt_q + 1'b1;
               end else if (active_q && evt.trail) begin
                  if (cnt_q == LAST) begin
                     done_q    <= 1'b1;
                     rx_data_q <= rx_q;
                     active_q  <= 1'b0;
                     cnt_q     <= '0;
                  end else begin
                     tx_q <= tx_shift;
                  end
               end
            end else begin
               if (evt.lead) begin
                  if (!active_q) begin
                     active_q <= 1'b1;
                     cnt_q    <= '0;
                     tx_q     <= tx_byte;
                  end else begin
                     tx_q <= tx_shift;
                  end
               end else if (active_q && evt.trail) begin
                  rx_q <= rx_next;
                  if (cnt_q == LAST_M1) begin
                     done_q    <= 1'b1;
                     rx_data_q <= rx_next;
                     active_q  <= 1'b0;
                     cnt_q     <= '0;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
         end
      end
   end

   assign miso       = active_q ? tx_q[DATA_W-1] : tx_byte[DATA_W-1];
   assign miso_oe    = en & ~ss_s;
   assign rx_data    = rx_data_q;
   assign rx_done    = done_q;
   assign mode_fault = fault_q;

   // R6
   fault_from_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode_fault |-> $past(active_q) && !active_q && cnt_q == '0);

   // R10
   done_fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(rx_done && mode_fault));

   // R9
   en_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !active_q && cnt_q == '0);

   // R3
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST);

   // R3
   done_from_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_done |-> $past(active_q) && !active_q);

   // R8
   idle_when_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ss_s |=> !active_q);

endmodule

// File: rtl/spi_target_shifter.sv
module spi_target_shifter
   import spi_sl_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              cpol,
   input  logic              cpha,
   input  logic              sck_in,
   input  logic              ss_n_in,
   input  logic              mosi_in,
   input  logic [DATA_W-1:0] tx_byte,
   output logic              miso,
   output logic              miso_oe,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_done,
   output logic              mode_fault
);

   localparam int          PIN_W    = 3;
   localparam logic [2:0]  PIN_RST  = 3'b010; // {sck, ss_n, mosi}

   logic [PIN_W-1:0] pins_s;
   logic             sck_s, ss_s, mosi_s;
   spi_evt_t         evt;

   spi_sl_sync #(
      .W       (PIN_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (PIN_RST)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({sck_in, ss_n_in, mosi_in}),
      .q     (pins_s)
   );

   assign sck_s  = pins_s[2];
   assign ss_s   = pins_s[1];
   assign mosi_s = pins_s[0];

   spi_sl_edges u_edges (
      .clk   (clk),
      .rst_n (rst_n),
      .cpol  (cpol),
      .sck_s (sck_s),
      .ss_s  (ss_s),
      .evt   (evt)
   );

   spi_sl_shifter #(
      .DATA_W (DATA_W)
   ) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (en),
      .cpha       (cpha),
      .evt        (evt),
      .ss_s       (ss_s),
      .mosi_s     (mosi_s),
      .tx_byte    (tx_byte),
      .miso       (miso),
      .miso_oe    (miso_oe),
      .rx_data    (rx_data),
      .rx_done    (rx_done),
      .mode_fault (mode_fault)
   );

   // R1
   oe_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      miso_oe |-> en);

endmodule

// File: tb/tb_spi_target_shifter.sv
module tb_spi_target_shifter;

   localparam int CLK_PERIOD = 10;
   localparam int HALF       = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b0;
   logic       cpol = 1'b0;
   logic       cpha = 1'b0;
   logic       sck = 1'b0;
   logic       ss_n = 1'b1;
   logic       mosi = 1'b0;
   logic [7:0] tx_byte = 8'h00;
   logic       miso, miso_oe, rx_done, mode_fault;
   logic [7:0] rx_data;

   spi_target_shifter dut (
      .clk(clk), .rst_n(rst_n), .en(en), .cpol(cpol), .cpha(cpha),
      .sck_in(sck), .ss_n_in(ss_n), .mosi_in(mosi), .tx_byte(tx_byte),
      .miso(miso), .miso_oe(miso_oe), .rx_data(rx_data),
      .rx_done(rx_done), .mode_fault(mode_fault)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int tests = 0, fails = 0, done_cnt = 0, fault_cnt = 0, exp_fault = 0, exp_done = 0;
   logic [7:0] exp_q[$];
   logic [7:0] popped;
   logic [7:0] mi;

   task automatic chk(input string req, input string what, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // monitor: pops expected words as the design reports them
   always @(negedge clk) begin
      if (rst_n) begin
         if (rx_done) begin
            done_cnt++;
            if (exp_q.size() == 0) begin
               tests++;
               fails++;
               $display("FAIL R6/R8/R10 unexpected word: actual %0h expected none", rx_data);
            end else begin
               popped = exp_q.pop_front();
               chk("R3/R4", "received word", int'(rx_data), int'(popped));
            end
         end
         if (mode_fault) fault_cnt++;
      end
   end

   task automatic wait_h();
      repeat (HALF) @(negedge clk);
   endtask

   task automatic setup_mode(input logic p, input logic h);
      cpol = p; cpha = h; sck = p;
      wait_h(); wait_h();
   endtask

   // master side: shifts nbits, captures MISO; optional deselect on final trail
   task automatic shift_bits(input logic [7:0] mo, input int nbits,
                             input bit desel_end, output logic [7:0] cap);
      cap = 8'h00;
      for (int i = 7; i > 7 - nbits; i--) begin
         if (!cpha) begin
            mosi = mo[i];
            wait_h();
            cap[i] = miso;
            sck = ~cpol;
            wait_h();
         end else begin
            sck = ~cpol;
            mosi = mo[i];
            wait_h();
            cap[i] = miso;
         end
         sck = cpol;
         if (desel_end && i == 8 - nbits) ss_n = 1'b1;
         wait_h();
      end
   endtask

   task automatic full_word(input logic [7:0] mo, input logic [7:0] tx, input string req);
      tx_byte = tx;
      ss_n = 1'b0;
      wait_h();
      exp_q.push_back(mo);
      exp_done++;
      shift_bits(mo, 8, 1'b0, mi);
      chk(req, "MISO word", int'(mi), int'(tx));
      ss_n = 1'b1;
      wait_h();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1", "oe in reset", int'(miso_oe), 0);
      chk("R1", "done in reset", int'(rx_done), 0);
      chk("R1", "fault in reset", int'(mode_fault), 0);
      rst_n = 1'b1;
      wait_h();

      // R1: selected but disabled, then enabled but deselected
      ss_n = 1'b0; wait_h();
      chk("R1", "oe with en=0", int'(miso_oe), 0);
      ss_n = 1'b1; en = 1'b1; wait_h();
      chk("R1", "oe deselected", int'(miso_oe), 0);

      // R2/R3: phase 0, polarity 0
      setup_mode(1'b0, 1'b0);
      tx_byte = 8'hB4;
      ss_n = 1'b0; wait_h();
      chk("R2", "MSB before clocks", int'(miso), 1);
      chk("R1", "oe selected", int'(miso_oe), 1);
      exp_q.push_back(8'hA5); exp_done++;
      shift_bits(8'hA5, 8, 1'b0, mi);
      chk("R2", "MISO word", int'(mi), 8'hB4);
      ss_n = 1'b1; wait_h();
      chk("R3", "done count", done_cnt, exp_done);
      chk("R3", "no fault after done", fault_cnt, exp_fault);

      // R5: phase 0, polarity 1
      setup_mode(1'b1, 1'b0);
      full_word(8'h19, 8'h6E, "R5");

      // R4: phase 1, polarity 0, two words under one select
      setup_mode(1'b0, 1'b1);
      tx_byte = 8'h5A;
      ss_n = 1'b0; wait_h();
      exp_q.push_back(8'hC3); exp_done++;
      shift_bits(8'hC3, 8, 1'b0, mi);
      chk("R4", "MISO word 1", int'(mi), 8'h5A);
      tx_byte = 8'h81;
      exp_q.push_back(8'h7E); exp_done++;
      shift_bits(8'h7E, 8, 1'b0, mi);
      chk("R4", "MISO word 2", int'(mi), 8'h81);
      ss_n = 1'b1; wait_h();
      chk("R4", "done count", done_cnt, exp_done);
      chk("R4", "no fault", fault_cnt, exp_fault);

      // R5: phase 1, polarity 1
      setup_mode(1'b1, 1'b1);
      full_word(8'h0F, 8'hF0, "R5");

      // R6: deselect mid-word, phase 0 then phase 1
      setup_mode(1'b0, 1'b0);
      ss_n = 1'b0; wait_h();
      shift_bits(8'hFF, 4, 1'b0, mi);
      ss_n = 1'b1; wait_h();
      exp_fault++;
      chk("R6", "fault phase 0", fault_cnt, exp_fault);
      setup_mode(1'b0, 1'b1);
      ss_n = 1'b0; wait_h();
      shift_bits(8'h00, 3, 1'b0, mi);
      ss_n = 1'b1; wait_h();
      exp_fault++;
      chk("R6", "fault phase 1", fault_cnt, exp_fault);
      chk("R6", "no word", done_cnt, exp_done);

      // R7: select/deselect with no clocks
      ss_n = 1'b0; wait_h(); ss_n = 1'b1; wait_h();
      chk("R7", "no fault phase 1", fault_cnt, exp_fault);
      setup_mode(1'b0, 1'b0);
      ss_n = 1'b0; wait_h(); ss_n = 1'b1; wait_h();
      exp_fault++;
      chk("R7", "fault phase 0", fault_cnt, exp_fault);

      // R8: clocks while deselected are ignored
      for (int k = 0; k < 5; k++) begin
         sck = 1'b1; wait_h(); sck = 1'b0; wait_h();
      end
      chk("R8", "no word", done_cnt, exp_done);
      chk("R8", "no fault", fault_cnt, exp_fault);
      // R9: en still set after earlier faults; word received normally
      full_word(8'h96, 8'h2D, "R8/R9");

      // R9: clear en mid-word
      tx_byte = 8'hFF;
      ss_n = 1'b0; wait_h();
      shift_bits(8'hAA, 3, 1'b0, mi);
      en = 1'b0; wait_h();
      chk("R9", "oe with en cleared", int'(miso_oe), 0);
      ss_n = 1'b1; wait_h();
      chk("R9", "no fault on abort", fault_cnt, exp_fault);
      chk("R9", "no word on abort", done_cnt, exp_done);
      en = 1'b1; wait_h();
      full_word(8'h4B, 8'hD2, "R9");

      // R10: final trail coincides with deselect
      setup_mode(1'b0, 1'b1);
      tx_byte = 8'h33;
      ss_n = 1'b0; wait_h();
      shift_bits(8'hE7, 8, 1'b1, mi);
      wait_h();
      exp_fault++;
      chk("R10", "fault wins", fault_cnt, exp_fault);
      chk("R10", "no word", done_cnt, exp_done);
      chk("R3", "queue drained", exp_q.size(), 0);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule